// File: doc/BRIEF.md
# Per-Destination Ingress Queue Scheduler

This block sits at the ingress of a packet switch and holds packet descriptors, each a packet handle and its length, in a separate first-in first-out lane for every output destination. An arriving descriptor carries a destination tag and goes only into that destination's lane. Because each output has its own lane, a descriptor that waits for a congested output never sits in front of traffic for another output, so one slow output cannot stall the rest.

Each output supplies a ready level. Every cycle the scheduler looks for lanes that hold at least one descriptor and whose output is ready. It serves them in rotating order and hands one descriptor per cycle to the fabric. An arrival for a lane that is already full is discarded, and that lane's saturating discard counter is incremented. The number of destinations, the lane depth and the counter width are parameters. The descriptor field widths come from the shared package.

Top module: `voq_sched`

## Requirements
- R1: While reset is asserted and right after it is released, `grantValid` is 0 and every discard counter in `dropCount` reads 0.
- R2: An arrival accepted at a clock edge can be granted in the cycle after that edge at the earliest, never in the cycle in which it is presented.
- R3: Within one lane, descriptors are granted in the order they arrived, with handle and length unchanged.
- R4: `grantValid` is 1 only when `grantDest` names a lane that holds a descriptor and whose `outReady` bit is 1. In every cycle in which such a lane exists, a grant is made. At most one descriptor is granted per cycle, and the grant takes effect at the next clock edge.
- R5: Selection rotates. After lane g is granted, the next grant goes to the first eligible lane in the order g+1, g+2, … with wrap-around. After reset the search starts at lane 0.
- R6: A lane whose `outReady` bit is 0 keeps its descriptors, and the other lanes continue to be served.
- R7: An arrival to a lane that holds DEPTH descriptors at the clock edge is discarded, even if that lane is granted in the same cycle. That lane's counter (bits [g*DROP_W +: DROP_W] of `dropCount` for lane g) increases by exactly 1. No other lane's contents or counter change.
- R8: An arrival to a lane that is not full, presented in the same cycle as a grant of that lane, is stored, and the granted descriptor is removed.
- R9: A discard counter stops at 2^DROP_W−1 and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | An arriving descriptor is presented this cycle |
| inDest | input | $clog2(NUM_DEST) | Destination lane of the arrival |
| inHandle | input | VOQ_HANDLE_W | Packet handle of the arrival |
| inLen | input | VOQ_LEN_W | Packet length of the arrival |
| outReady | input | NUM_DEST | Per-output ready level, bit g for lane g |
| grantValid | output | 1 | A descriptor is granted this cycle |
| grantDest | output | $clog2(NUM_DEST) | Lane of the granted descriptor |
| grantHandle | output | VOQ_HANDLE_W | Handle of the granted descriptor |
| grantLen | output | VOQ_LEN_W | Length of the granted descriptor |
| dropCount | output | NUM_DEST*DROP_W | Saturating discard counters, lane g at [g*DROP_W +: DROP_W] |

## Verification
The grant is combinational from lane state and `outReady`, so it is due in the same cycle as the ready level that enables it. It is due one cycle after the edge that stored the descriptor, and lane removal happens at the following edge. Discard counters change at the edge that sees the arrival to a full lane. The bench drives inputs just after the falling edge and compares the grant and all counters a nanosecond later, before the rising edge that commits them. A queue-based model then applies that same edge, popping first and deciding the discard on the occupancy seen before the edge. The model's comparison therefore lands on exactly the cycle each result becomes due.

// File: rtl/voq_pkg.sv
package voq_pkg;
  localparam int unsigned VOQ_MAX_DEST = 16;
  localparam int unsigned VOQ_SEL_W    = $clog2(VOQ_MAX_DEST);
  localparam int unsigned VOQ_HANDLE_W = 12;
  localparam int unsigned VOQ_LEN_W    = 14;

  typedef struct packed {
    logic [VOQ_HANDLE_W-1:0] handle;
    logic [VOQ_LEN_W-1:0]    len;
  } voq_desc_t;

  // strobes from control to datapath, one bit per lane
  typedef struct packed {
    logic [VOQ_MAX_DEST-1:0] pushMask;
    logic [VOQ_MAX_DEST-1:0] popMask;
    logic [VOQ_MAX_DEST-1:0] dropMask;
    logic [VOQ_SEL_W-1:0]    sel;
  } voq_strobe_t;
endpackage

// File: rtl/voq_lanes.sv
module voq_lanes
  import voq_pkg::*;
#(
  parameter int unsigned NUM_DEST = 4,
  parameter int unsigned DEPTH    = 4,
  parameter int unsigned DROP_W   = 8,
  localparam int unsigned DW = (NUM_DEST > 1) ? $clog2(NUM_DEST) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  voq_strobe_t                strobe,
  input  voq_desc_t                  inDesc,
  output logic [NUM_DEST-1:0]        laneEmpty,
  output logic [NUM_DEST-1:0]        laneFull,
  output voq_desc_t                  grantDesc,
  output logic [NUM_DEST*DROP_W-1:0] dropCount
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  voq_desc_t heads [NUM_DEST];

  for (genvar g = 0; g < NUM_DEST; g++) begin : gLane
    voq_desc_t         mem [DEPTH];
    logic [PW-1:0]     rdPtr;
    logic [PW-1:0]     wrPtr;
    logic [CW-1:0]     cnt;
    logic [DROP_W-1:0] drops;
    logic              doPush;
    logic              doPop;

    assign doPush = strobe.pushMask[g];
    assign doPop  = strobe.popMask[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rdPtr <= '0;
        wrPtr <= '0;
        cnt   <= '0;
        drops <= '0;
      end else begin
        if (doPush) wrPtr <= (wrPtr == PW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
        if (doPop)  rdPtr <= (rdPtr == PW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
        cnt <= cnt + CW'(doPush) - CW'(doPop);
        if (strobe.dropMask[g] && (drops != '1)) drops <= drops + 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (doPush) mem[wrPtr] <= inDesc;
    end

    assign laneEmpty[g] = (cnt == '0);
    assign laneFull[g]  = (cnt == CW'(DEPTH));
    assign heads[g]     = mem[rdPtr];
    assign dropCount[g*DROP_W +: DROP_W] = drops;
  end

  assign grantDesc = heads[strobe.sel[DW-1:0]];
endmodule

// File: rtl/voq_ctrl.sv
module voq_ctrl
  import voq_pkg::*;
#(
  parameter int unsigned NUM_DEST = 4,
  localparam int unsigned DW = (NUM_DEST > 1) ? $clog2(NUM_DEST) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                inValid,
  input  logic [DW-1:0]       inDest,
  input  logic [NUM_DEST-1:0] outReady,
  input  logic [NUM_DEST-1:0] laneEmpty,
  input  logic [NUM_DEST-1:0] laneFull,
  output voq_strobe_t         strobe,
  output logic                grantValid
);
  logic [DW-1:0]       lastGrant;
  logic [DW-1:0]       pick;
  logic                found;
  logic [NUM_DEST-1:0] eligible;

  assign eligible = ~laneEmpty & outReady;

  // rotating search beginning just after the last granted lane
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = 1; k <= NUM_DEST; k++) begin
      int unsigned idx;
      idx = (int'(lastGrant) + k) % NUM_DEST;
      if (!found && eligible[idx]) begin
        found = 1'b1;
        pick  = DW'(idx);
      end
    end
  end

  always_comb begin
    strobe      = '0;
    strobe.sel  = VOQ_SEL_W'(pick);
    strobe.popMask[pick] = found;
    strobe.pushMask[inDest] = inValid && !laneFull[inDest];
    strobe.dropMask[inDest] = inValid &&  laneFull[inDest];
  end

  assign grantValid = found;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lastGrant <= DW'(NUM_DEST - 1);
    else if (found) lastGrant <= pick;
  end
endmodule

// File: rtl/voq_sched.sv
module voq_sched
  import voq_pkg::*;
#(
  parameter int unsigned NUM_DEST = 4,
  parameter int unsigned DEPTH    = 4,
  parameter int unsigned DROP_W   = 8,
  localparam int unsigned DW = (NUM_DEST > 1) ? $clog2(NUM_DEST) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       inValid,
  input  logic [DW-1:0]              inDest,
  input  logic [VOQ_HANDLE_W-1:0]    inHandle,
  input  logic [VOQ_LEN_W-1:0]       inLen,
  input  logic [NUM_DEST-1:0]        outReady,
  output logic                       grantValid,
  output logic [DW-1:0]              grantDest,
  output logic [VOQ_HANDLE_W-1:0]    grantHandle,
  output logic [VOQ_LEN_W-1:0]       grantLen,
  output logic [NUM_DEST*DROP_W-1:0] dropCount
);
  voq_strobe_t         strobe;
  voq_desc_t           inDesc;
  voq_desc_t           grantDesc;
  logic [NUM_DEST-1:0] laneEmpty;
  logic [NUM_DEST-1:0] laneFull;

  assign inDesc.handle = inHandle;
  assign inDesc.len    = inLen;

  voq_ctrl #(.NUM_DEST(NUM_DEST)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inDest(inDest),
    .outReady(outReady), .laneEmpty(laneEmpty), .laneFull(laneFull),
    .strobe(strobe), .grantValid(grantValid)
  );

  voq_lanes #(.NUM_DEST(NUM_DEST), .DEPTH(DEPTH), .DROP_W(DROP_W)) lanes_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .inDesc(inDesc),
    .laneEmpty(laneEmpty), .laneFull(laneFull), .grantDesc(grantDesc),
    .dropCount(dropCount)
  );

  assign grantDest   = strobe.sel[DW-1:0];
  assign grantHandle = grantDesc.handle;
  assign grantLen    = grantDesc.len;
endmodule

// File: rtl/voq_sched_chk.sv
module voq_sched_chk #(
  parameter int unsigned NUM_DEST = 4,
  parameter int unsigned DROP_W   = 8,
  localparam int unsigned DW = (NUM_DEST > 1) ? $clog2(NUM_DEST) : 1
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       inValid,
  input logic [DW-1:0]              inDest,
  input logic [NUM_DEST-1:0]        outReady,
  input logic                       grantValid,
  input logic [DW-1:0]              grantDest,
  input logic [NUM_DEST*DROP_W-1:0] dropCount,
  input logic [NUM_DEST-1:0]        laneEmpty,
  input logic [NUM_DEST-1:0]        laneFull
);
  // R4: a grant targets a stored descriptor whose output is ready
  a_r4_grant_ready: assert property (@(posedge clk) disable iff (!rst_n)
    grantValid |-> (outReady[grantDest] && !laneEmpty[grantDest]));

  // R4: no eligible lane is left idle
  a_r4_work_conserving: assert property (@(posedge clk) disable iff (!rst_n)
    (|(~laneEmpty & outReady)) |-> grantValid);

  for (genvar g = 0; g < NUM_DEST; g++) begin : gChk
    // R7: a counter moves only after an arrival to its full lane
    a_r7_drop_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (dropCount[g*DROP_W +: DROP_W] != $past(dropCount[g*DROP_W +: DROP_W]))
        |-> $past(inValid && (inDest == DW'(g)) && laneFull[g]));

    // R7, R9: a counter moves up by one and never wraps
    a_r9_drop_step: assert property (@(posedge clk) disable iff (!rst_n)
      (dropCount[g*DROP_W +: DROP_W] != $past(dropCount[g*DROP_W +: DROP_W]))
        |-> (dropCount[g*DROP_W +: DROP_W] == $past(dropCount[g*DROP_W +: DROP_W]) + 1'b1));
  end
endmodule

bind voq_sched voq_sched_chk #(.NUM_DEST(NUM_DEST), .DROP_W(DROP_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .inValid(inValid), .inDest(inDest),
  .outReady(outReady), .grantValid(grantValid), .grantDest(grantDest),
  .dropCount(dropCount), .laneEmpty(laneEmpty), .laneFull(laneFull)
);

// File: tb/voq_sched_tb.sv
`timescale 1ns/1ps
module voq_sched_tb_top;
  import voq_pkg::*;
  localparam int NUM_DEST = 4;
  localparam int DEPTH    = 4;
  localparam int DROP_W   = 8;
  localparam int DW       = $clog2(NUM_DEST);
  localparam int DROP_MAX = (1 << DROP_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inValid = 1'b0;
  logic [DW-1:0] inDest = '0;
  logic [VOQ_HANDLE_W-1:0] inHandle = '0;
  logic [VOQ_LEN_W-1:0] inLen = '0;
  logic [NUM_DEST-1:0] outReady = '0;
  logic grantValid;
  logic [DW-1:0] grantDest;
  logic [VOQ_HANDLE_W-1:0] grantHandle;
  logic [VOQ_LEN_W-1:0] grantLen;
  logic [NUM_DEST*DROP_W-1:0] dropCount;

  always #5 clk = ~clk;

  voq_sched #(.NUM_DEST(NUM_DEST), .DEPTH(DEPTH), .DROP_W(DROP_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inDest(inDest),
    .inHandle(inHandle), .inLen(inLen), .outReady(outReady),
    .grantValid(grantValid), .grantDest(grantDest), .grantHandle(grantHandle),
    .grantLen(grantLen), .dropCount(dropCount)
  );

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  // reference state
  int q [NUM_DEST][$];
  int mDrops [NUM_DEST];
  int mLast = NUM_DEST - 1;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compareAll();
    int pick = -1;
    for (int k = 1; k <= NUM_DEST; k++) begin
      int idx = (mLast + k) % NUM_DEST;
      if (pick < 0 && q[idx].size() > 0 && outReady[idx]) pick = idx;
    end
    chk(grantValid === (pick >= 0), "grantValid", int'(grantValid), int'(pick >= 0));
    if (pick >= 0 && grantValid === 1'b1) begin
      int e = q[pick][0];
      chk(int'(grantDest) == pick, "grantDest", int'(grantDest), pick);
      chk(int'(grantHandle) == (e >> VOQ_LEN_W), "grantHandle", int'(grantHandle), e >> VOQ_LEN_W);
      chk(int'(grantLen) == (e & ((1 << VOQ_LEN_W) - 1)), "grantLen", int'(grantLen),
          e & ((1 << VOQ_LEN_W) - 1));
    end
    for (int g = 0; g < NUM_DEST; g++)
      chk(int'(dropCount[g*DROP_W +: DROP_W]) == mDrops[g], "dropCount",
          int'(dropCount[g*DROP_W +: DROP_W]), mDrops[g]);
    // apply the coming edge to the model
    if (pick >= 0) begin
      void'(q[pick].pop_front());
      mLast = pick;
    end
  endtask

  task automatic tick(input bit v, input int d, input int h, input int l, input logic [NUM_DEST-1:0] rdy);
    int fullBefore;
    @(negedge clk);
    inValid = v; inDest = DW'(d); inHandle = VOQ_HANDLE_W'(h); inLen = VOQ_LEN_W'(l);
    outReady = rdy;
    fullBefore = (q[d].size() == DEPTH);
    #1;
    compareAll();
    if (v) begin
      if (fullBefore != 0) begin
        if (mDrops[d] < DROP_MAX) mDrops[d]++;
      end else q[d].push_back((h << VOQ_LEN_W) | l);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    tag = "R1";
    chk(grantValid === 1'b0, "grantValid in reset", int'(grantValid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(grantValid === 1'b0, "grantValid after reset", int'(grantValid), 0);
    chk(dropCount === '0, "dropCount after reset", int'(dropCount), 0);

    // R2: arrival is not granted in its own cycle
    tag = "R2";
    tick(1, 2, 'h11, 5, '1);
    tick(0, 0, 0, 0, '1);

    // R3: order kept inside a lane
    tag = "R3";
    for (int i = 1; i <= 3; i++) tick(1, 0, 'h100 + i, i, 4'b1110);
    for (int i = 0; i < 4; i++) tick(0, 0, 0, 0, '1);

    // R6, R7: lane 1 blocked and overfilled, lane 0 still served
    tag = "R6 R7";
    for (int i = 0; i < 6; i++) begin
      tick(1, 1, 'h200 + i, 10 + i, 4'b1101);
      tick(1, 0, 'h300 + i, 20 + i, 4'b1101);
    end
    for (int i = 0; i < 6; i++) tick(0, 0, 0, 0, '1);

    // R7: full lane granted in same cycle still discards; R8: push and pop together
    tag = "R7 R8";
    for (int i = 0; i < 4; i++) tick(1, 2, 'h400 + i, i, 4'b1011);
    tick(1, 2, 'h4AA, 7, 4'b0100);
    tick(1, 2, 'h4BB, 8, 4'b0100);
    for (int i = 0; i < 6; i++) tick(0, 0, 0, 0, '1);

    // R3, R4, R5: mixed traffic with rotating selection
    tag = "R3 R4 R5";
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 99);
      tick(r < 70, $urandom_range(0, NUM_DEST - 1), $urandom_range(0, 4095),
           $urandom_range(0, 16383), NUM_DEST'($urandom_range(0, 15) | (r < 20 ? 0 : 'hF)));
    end
    for (int i = 0; i < 20; i++) tick(0, 0, 0, 0, '1);

    // R9: counter saturation on lane 3
    tag = "R9";
    for (int i = 0; i < 300; i++) tick(1, 3, i, i, 4'b0111);
    chk(int'(dropCount[3*DROP_W +: DROP_W]) == DROP_MAX, "saturated count",
        int'(dropCount[3*DROP_W +: DROP_W]), DROP_MAX);
    for (int i = 0; i < 8; i++) tick(0, 0, 0, 0, '1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule